// File: doc/BRIEF.md
# Nibble Bit-Test and Shift Execute Unit

This unit is the execute stage of a 4-bit controller for one group of instructions: conditional skips that test bits, carry-linked right shift and right rotate, and a bit-order reversal of a memory nibble. Each cycle it may receive a 16-bit instruction word with a valid strobe. The word holds a 6-bit opcode in bits 15:10, a 2-bit row field in bits 9:8, a 4-bit column field in bits 7:4 and a 4-bit low field in bits 3:0. The unit drives the 6-bit data-memory address `{row, column}` and the general-register index (the low field) as combinational outputs. It then takes in the addressed memory nibble and the selected register value.

One clock after the strobe, the unit presents its results. These are a skip request for the sequencer, and a write-back enable with its address and data for the memory. The carry flag is held in the unit and is updated at the same edge. Program-counter handling, instruction fetch, wait and clock-stop belong to other blocks.

Top module: `nib_bit_unit`

## Requirements
- R1: Opcode 110101 skips when every memory bit selected by the low-field mask is 1. Opcode 110111 skips when every selected memory bit is 0.
- R2: Opcode 110100 skips when the selected memory bits are not all 1. Opcode 110110 skips when the selected memory bits are not all 0.
- R3: Opcode 010000 skips when every bit of the register named by the low field is 1 wherever the memory nibble has a 1. Opcode 010001 skips when all of those register bits are 0. The reg_sel output equals the low field.
- R4: When the mask is all zero, the tests of R1 and R3 skip and the tests of R2 do not.
- R5: Opcode 111111 with low field 0000 writes `{0, m[3:1]}` back to the addressed nibble and loads the carry with m[0].
- R6: Opcode 111111 with low field 0001 writes `{carry, m[3:1]}` back and loads the carry with m[0].
- R7: Opcode 111111 with low field 0110 writes back the nibble with its bit order reversed and leaves the carry unchanged.
- R8: Opcode 111111 with low field 0011 skips when the carry is 1 if the row is 00, and when the carry is 0 if the row is 01. With rows 10 and 11 it does not skip.
- R9: The write-back enable is asserted only for the encodings of R5 to R7. For every other word, including unassigned ones, no write happens and the carry is not changed.
- R10: skip_o and wb_en_o are pulses that are valid one clock after the strobe. With no strobe, both are 0 and the carry holds its value. The mem_addr output equals `{row, column}`, and wb_addr_o returns that address.
- R11: After reset, skip_o, wb_en_o and carry_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| mem_addr | output | 6 | Data-memory read address `{row, column}` |
| mem_rdata | input | 4 | Addressed memory nibble |
| reg_sel | output | 4 | General-register index |
| reg_rdata | input | 4 | Selected register value |
| skip_o | output | 1 | Skip request, one cycle after the strobe |
| wb_en_o | output | 1 | Memory write enable |
| wb_addr_o | output | 6 | Memory write address |
| wb_data_o | output | 4 | Memory write data |
| carry_o | output | 1 | Carry flag |

## Verification
Every registered result (skip_o, wb_en_o, wb_addr_o, wb_data_o and the carry) is due at the first rising edge after the edge that samples the strobe. The bench drives the strobe and operands on a falling edge and lets one rising edge pass. It drops the strobe on the next falling edge and samples all results there, half a period away from either active edge. The combinational addresses are checked before that edge. After reset, the bench waits out the two-stage reset synchroniser before it checks the reset state. It then runs an idle cycle to confirm that the pulses fall back to 0.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NW  = 4;
  localparam int OPW = 6;
  localparam int RW  = 2;
  localparam int CW  = 4;
  localparam int LW  = 4;
  localparam int IW  = OPW + RW + CW + LW;
  localparam int AW  = RW + CW;

  localparam logic [OPW-1:0] OPC_TST_ONE   = 6'b110101;
  localparam logic [OPW-1:0] OPC_TST_ZERO  = 6'b110111;
  localparam logic [OPW-1:0] OPC_TST_NONE1 = 6'b110100;
  localparam logic [OPW-1:0] OPC_TST_NONE0 = 6'b110110;
  localparam logic [OPW-1:0] OPC_REG_ONE   = 6'b010000;
  localparam logic [OPW-1:0] OPC_REG_ZERO  = 6'b010001;
  localparam logic [OPW-1:0] OPC_MISC      = 6'b111111;

  localparam logic [LW-1:0] SUB_SHR  = 4'b0000;
  localparam logic [LW-1:0] SUB_RRC  = 4'b0001;
  localparam logic [LW-1:0] SUB_CSK  = 4'b0011;
  localparam logic [LW-1:0] SUB_SWAP = 4'b0110;

  typedef enum logic [3:0] {
    K_NONE, K_TST_ONE, K_TST_ZERO, K_TST_NONE1, K_TST_NONE0,
    K_REG_ONE, K_REG_ZERO, K_SHR, K_RRC, K_SWAP, K_SKIP_C, K_SKIP_NC
  } kind_e;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  logic [IW-1:0] instr,
  output kind_e         kind,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] low
);
  logic [OPW-1:0] opc;
  logic [RW-1:0]  row;

  assign opc  = instr[IW-1 -: OPW];
  assign row  = instr[LW+CW +: RW];
  assign low  = instr[LW-1:0];
  assign addr = instr[LW +: AW];

  always_comb begin
    kind = K_NONE;
    unique case (opc)
      OPC_TST_ONE:   kind = K_TST_ONE;
      OPC_TST_ZERO:  kind = K_TST_ZERO;
      OPC_TST_NONE1: kind = K_TST_NONE1;
      OPC_TST_NONE0: kind = K_TST_NONE0;
      OPC_REG_ONE:   kind = K_REG_ONE;
      OPC_REG_ZERO:  kind = K_REG_ZERO;
      OPC_MISC: begin
        unique case (low)
          SUB_SHR:  kind = K_SHR;
          SUB_RRC:  kind = K_RRC;
          SUB_SWAP: kind = K_SWAP;
          SUB_CSK: begin
            if (row == 2'b00)      kind = K_SKIP_C;
            else if (row == 2'b01) kind = K_SKIP_NC;
            else                   kind = K_NONE;
          end
          default:  kind = K_NONE;
        endcase
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/nib_skip.sv
module nib_skip
  import nib_pkg::*;
(
  input  kind_e         kind,
  input  logic [NW-1:0] imm_mask,
  input  logic [NW-1:0] mem,
  input  logic [NW-1:0] regv,
  input  logic          carry,
  output logic          skip
);
  logic [NW-1:0] tdata;
  logic [NW-1:0] tmask;
  logic          ones_ok;
  logic          zeros_ok;

  always_comb begin
    if (kind == K_REG_ONE || kind == K_REG_ZERO) begin
      tdata = regv;
      tmask = mem;
    end else begin
      tdata = mem;
      tmask = imm_mask;
    end
    ones_ok  = ((~tdata) & tmask) == '0;
    zeros_ok = (tdata & tmask) == '0;
  end

  always_comb begin
    unique case (kind)
      K_TST_ONE, K_REG_ONE:   skip = ones_ok;
      K_TST_ZERO, K_REG_ZERO: skip = zeros_ok;
      K_TST_NONE1:            skip = !ones_ok;
      K_TST_NONE0:            skip = !zeros_ok;
      K_SKIP_C:               skip = carry;
      K_SKIP_NC:              skip = !carry;
      default:                skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/nib_shift.sv
module nib_shift
  import nib_pkg::*;
(
  input  kind_e         kind,
  input  logic [NW-1:0] din,
  input  logic          cin,
  output logic [NW-1:0] dout,
  output logic          cout,
  output logic          wen,
  output logic          cen
);
  logic [NW-1:0] rev;

  for (genvar g = 0; g < NW; g++) begin : g_rev
    assign rev[g] = din[NW-1-g];
  end

  always_comb begin
    dout = din;
    cout = cin;
    wen  = 1'b0;
    cen  = 1'b0;
    unique case (kind)
      K_SHR: begin
        dout = {1'b0, din[NW-1:1]};
        cout = din[0];
        wen  = 1'b1;
        cen  = 1'b1;
      end
      K_RRC: begin
        dout = {cin, din[NW-1:1]};
        cout = din[0];
        wen  = 1'b1;
        cen  = 1'b1;
      end
      K_SWAP: begin
        dout = rev;
        wen  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_bit_unit.sv
module nib_bit_unit
  import nib_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr,
  output logic [5:0]    mem_addr,
  input  logic [3:0]    mem_rdata,
  output logic [3:0]    reg_sel,
  input  logic [3:0]    reg_rdata,
  output logic          skip_o,
  output logic          wb_en_o,
  output logic [5:0]    wb_addr_o,
  output logic [3:0]    wb_data_o,
  output logic          carry_o
);
  logic          rs_meta, rs_n;
  kind_e         kind;
  logic [LW-1:0] low;
  logic          skip_c, wen_c, cen_c, cout_c;
  logic [NW-1:0] res_c;

  logic          skip_q, skip_d, wen_q, wen_d, carry_q, carry_d;
  logic [AW-1:0] waddr_q, waddr_d;
  logic [NW-1:0] wdata_q, wdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  nib_decode u_dec (
    .instr (instr),
    .kind  (kind),
    .addr  (mem_addr),
    .low   (low)
  );

  assign reg_sel = low;

  nib_skip u_skip (
    .kind     (kind),
    .imm_mask (low),
    .mem      (mem_rdata),
    .regv     (reg_rdata),
    .carry    (carry_q),
    .skip     (skip_c)
  );

  nib_shift u_shift (
    .kind (kind),
    .din  (mem_rdata),
    .cin  (carry_q),
    .dout (res_c),
    .cout (cout_c),
    .wen  (wen_c),
    .cen  (cen_c)
  );

  always_comb begin
    skip_d  = instr_valid & skip_c;
    wen_d   = instr_valid & wen_c;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    carry_d = carry_q;
    if (instr_valid) begin
      waddr_d = mem_addr;
      wdata_d = res_c;
      if (cen_c) carry_d = cout_c;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      skip_q  <= 1'b0;
      wen_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      carry_q <= 1'b0;
    end else begin
      skip_q  <= skip_d;
      wen_q   <= wen_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      carry_q <= carry_d;
    end
  end

  assign skip_o    = skip_q;
  assign wb_en_o   = wen_q;
  assign wb_addr_o = waddr_q;
  assign wb_data_o = wdata_q;
  assign carry_o   = carry_q;

  // R10: pulses stay low and carry holds when no strobe was given
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rs_n)
    !instr_valid |=> (!skip_o && !wb_en_o && $stable(carry_o)));

  // R5: shift fills bit 3 with zero and moves bit 0 to carry
  a_r5_shift_fill: assert property (@(posedge clk) disable iff (!rs_n)
    (instr_valid && instr == {OPC_MISC, 2'b00, 4'h0, SUB_SHR}) |=>
      (wb_en_o && !wb_data_o[NW-1] && carry_o == $past(mem_rdata[0])));

  // R6: rotate brings the previous carry into bit 3
  a_r6_rotate_in: assert property (@(posedge clk) disable iff (!rs_n)
    (instr_valid && instr[IW-1 -: OPW] == OPC_MISC && instr[LW-1:0] == SUB_RRC) |=>
      (wb_data_o[NW-1] == $past(carry_o) && carry_o == $past(mem_rdata[0])));

  // R7: exchange keeps the carry
  a_r7_swap_carry: assert property (@(posedge clk) disable iff (!rs_n)
    (instr_valid && instr[IW-1 -: OPW] == OPC_MISC && instr[LW-1:0] == SUB_SWAP) |=>
      (wb_en_o && $stable(carry_o)));

  // R9: test opcodes never write memory
  a_r9_test_no_write: assert property (@(posedge clk) disable iff (!rs_n)
    (instr_valid && instr[IW-1 -: OPW] != OPC_MISC) |=> (!wb_en_o && $stable(carry_o)));
endmodule

// File: tb/nib_bit_unit_tb.sv
module nib_bit_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  mem_rdata = '0;
  logic [3:0]  reg_rdata = '0;
  logic [5:0]  mem_addr, wb_addr_o;
  logic [3:0]  reg_sel, wb_data_o;
  logic        skip_o, wb_en_o, carry_o;

  int n_run = 0;
  int n_fail = 0;
  logic exp_c = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nib_bit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .skip_o(skip_o), .wb_en_o(wb_en_o),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .carry_o(carry_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [5:0] op, input logic [1:0] row,
                                     input logic [3:0] col, input logic [3:0] lo);
    return {op, row, col, lo};
  endfunction

  // Runs one instruction and checks every registered result against a bit-level model.
  task automatic run(input string req, input logic [15:0] w, input logic [3:0] m,
                     input logic [3:0] r);
    logic [5:0] op;
    logic [3:0] lo, d, k, wd;
    logic       all1, all0, sk, we, nc;
    op = w[15:10]; lo = w[3:0];
    all1 = 1'b1; all0 = 1'b1;
    if (op == 6'b010000 || op == 6'b010001) begin d = r; k = m; end
    else begin d = m; k = lo; end
    for (int i = 0; i < 4; i++)
      if (k[i]) begin
        if (!d[i]) all1 = 1'b0;
        if (d[i])  all0 = 1'b0;
      end
    sk = 1'b0; we = 1'b0; wd = 4'h0; nc = exp_c;
    case (op)
      6'b110101, 6'b010000: sk = all1;
      6'b110111, 6'b010001: sk = all0;
      6'b110100: sk = !all1;
      6'b110110: sk = !all0;
      6'b111111: begin
        if (lo == 4'b0000) begin we = 1'b1; wd = m >> 1; nc = m[0]; end
        else if (lo == 4'b0001) begin we = 1'b1; wd = (m >> 1) | {exp_c, 3'b000}; nc = m[0]; end
        else if (lo == 4'b0110) begin
          we = 1'b1;
          for (int i = 0; i < 4; i++) wd[i] = m[3-i];
        end else if (lo == 4'b0011) begin
          if (w[9:8] == 2'b00) sk = exp_c;
          else if (w[9:8] == 2'b01) sk = !exp_c;
        end
      end
      default: ;
    endcase
    @(negedge clk);
    instr = w; mem_rdata = m; reg_rdata = r; instr_valid = 1'b1;
    #1;
    chk({req, " mem_addr (R10)"}, int'(mem_addr), int'(w[9:4]));
    chk({req, " reg_sel (R3)"}, int'(reg_sel), int'(lo));
    @(negedge clk);
    instr_valid = 1'b0;
    chk({req, " skip"}, int'(skip_o), int'(sk));
    chk({req, " wb_en (R9)"}, int'(wb_en_o), int'(we));
    if (we) begin
      chk({req, " wb_data"}, int'(wb_data_o), int'(wd));
      chk({req, " wb_addr (R10)"}, int'(wb_addr_o), int'(w[9:4]));
    end
    exp_c = nc;
    chk({req, " carry"}, int'(carry_o), int'(exp_c));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_c = 1'b0;
    chk("R11 skip", int'(skip_o), 0);
    chk("R11 wb_en", int'(wb_en_o), 0);
    chk("R11 carry", int'(carry_o), 0);
  endtask

  task automatic t_mem_tests();
    for (int m = 0; m < 16; m++)
      for (int k = 1; k < 16; k += 3) begin
        run("R1 true", mk(6'b110101, 2'(m), 4'(k), 4'(k)), 4'(m), 4'h0);
        run("R1 false", mk(6'b110111, 2'b11, 4'(m), 4'(k)), 4'(m), 4'h0);
        run("R2 not-true", mk(6'b110100, 2'b10, 4'h5, 4'(k)), 4'(m), 4'h0);
        run("R2 not-false", mk(6'b110110, 2'b01, 4'hA, 4'(k)), 4'(m), 4'h0);
      end
  endtask

  task automatic t_reg_tests();
    for (int r = 0; r < 16; r++)
      for (int m = 1; m < 16; m += 2) begin
        run("R3 reg true", mk(6'b010000, 2'b01, 4'h3, 4'(r)), 4'(m), 4'(r));
        run("R3 reg false", mk(6'b010001, 2'b10, 4'hC, 4'(15 - r)), 4'(m), 4'(r));
      end
  endtask

  task automatic t_empty_mask();
    for (int v = 0; v < 16; v += 5) begin
      run("R4 true", mk(6'b110101, 2'b00, 4'h1, 4'h0), 4'(v), 4'h0);
      run("R4 false", mk(6'b110111, 2'b00, 4'h1, 4'h0), 4'(v), 4'h0);
      run("R4 not-true", mk(6'b110100, 2'b00, 4'h1, 4'h0), 4'(v), 4'h0);
      run("R4 not-false", mk(6'b110110, 2'b00, 4'h1, 4'h0), 4'(v), 4'h0);
      run("R4 reg", mk(6'b010000, 2'b00, 4'h1, 4'h2), 4'h0, 4'(v));
    end
  endtask

  task automatic t_shift();
    for (int m = 0; m < 16; m++)
      run("R5 shift", mk(6'b111111, 2'(m), 4'(15 - m), 4'b0000), 4'(m), 4'h0);
  endtask

  task automatic t_rotate();
    for (int m = 0; m < 16; m++)
      run("R6 rotate", mk(6'b111111, 2'b10, 4'(m), 4'b0001), 4'(m ^ 5), 4'h0);
  endtask

  task automatic t_swap();
    run("R7 prep", mk(6'b111111, 2'b00, 4'h0, 4'b0000), 4'h1, 4'h0);
    for (int m = 0; m < 16; m++)
      run("R7 swap", mk(6'b111111, 2'b11, 4'(m), 4'b0110), 4'(m), 4'h0);
  endtask

  task automatic t_carry_skip();
    for (int c = 0; c < 2; c++) begin
      run("R8 set carry", mk(6'b111111, 2'b00, 4'h0, 4'b0000), 4'(c), 4'h0);
      for (int row = 0; row < 4; row++)
        run("R8 carry skip", mk(6'b111111, 2'(row), 4'h7, 4'b0011), 4'hF, 4'h0);
    end
  endtask

  task automatic t_no_write();
    run("R9 set carry", mk(6'b111111, 2'b00, 4'h0, 4'b0000), 4'h1, 4'h0);
    for (int lo = 0; lo < 16; lo++)
      run("R9 misc", mk(6'b111111, 2'b01, 4'h2, 4'(lo)), 4'h6, 4'h0);
    run("R9 unassigned", mk(6'b000000, 2'b01, 4'h2, 4'h1), 4'h6, 4'h0);
    run("R9 unassigned", mk(6'b110000, 2'b00, 4'h0, 4'hF), 4'hF, 4'h0);
  endtask

  task automatic t_idle();
    run("R10 prep", mk(6'b110101, 2'b00, 4'h0, 4'h0), 4'h0, 4'h0);
    @(negedge clk);
    instr = mk(6'b111111, 2'b00, 4'h0, 4'b0000); mem_rdata = 4'hF;
    @(negedge clk);
    chk("R10 idle skip", int'(skip_o), 0);
    chk("R10 idle wb_en", int'(wb_en_o), 0);
    chk("R10 idle carry", int'(carry_o), int'(exp_c));
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mem_tests();
    t_reg_tests();
    t_empty_mask();
    t_shift();
    t_rotate();
    t_swap();
    t_carry_skip();
    t_no_write();
    t_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule